// File: doc/BRIEF.md
# SPI Target Command Frame Processor

This block sits behind a byte-level SPI shifter on the target side of a register-access link. Each byte the shifter assembles arrives on a valid/ready receive stream. The first byte of a frame is an opcode. The block then takes exactly as many address, data and check bytes as that opcode calls for. Once the frame is complete it carries out one 32-bit access on a simple internal register port and queues a reply. The reply leaves on a valid/ready transmit stream that the shifter drains.

Four opcodes perform accesses. A single write (0xC9) and a single read (0xCA) use a 24-bit address. An internal write (0xC3) and an internal read (0xC4) use a 15-bit address together with a clockless flag. Every other opcode is answered with an error status. One internal address is a protocol configuration register held inside the block. Its bits 3:2 turn CRC7 checking of command frames on or off, and its bits 6:4 hold a packet-size code.

Both streams follow the usual rule: a byte moves on a clock edge where valid and ready are both high. The receive side holds ready low from the moment a frame is complete until its reply has been drained. The transmit side holds each byte stable until the shifter accepts it. When the frame-select input goes low, the current frame or reply is dropped.

Top module: `spi_cmd_target`

## Requirements
- R1: After each complete frame the reply begins with the received opcode, followed by a status byte. Status 0x00 means success, 0x01 means a command CRC mismatch and 0x02 means an unsupported opcode. A successful register access is followed by a reply in the next cycle.
- R2: A single write frame (0xC9) carries three address bytes, most significant first, then four data bytes, most significant first. It produces exactly one reg_wr strobe with that address and data, reg_internal low and reg_clockless low. Its reply is two bytes long.
- R3: A successful read reply (0xCA or 0xC4) has the form opcode, 0x00, header 0xF0, then the four bytes of the read word, least significant first.
- R4: An internal frame takes two address bytes. Bit 7 of the first byte drives reg_clockless, and the remaining 15 bits form reg_addr, with zeros above them. A read (0xC4) takes one more byte, whose value is ignored. A write (0xC3) takes four data bytes, most significant first. Both raise reg_internal.
- R5: With CRC on, one check byte follows the command bytes. Its bits 7:1 must equal the CRC7 of the opcode and command bytes, taken MSB first with polynomial x^7+x^3+1 and the register preset to 0x7F. Its bit 0 is ignored. On a mismatch the status is 0x01 and no register strobe is raised.
- R6: An opcode other than 0xC3, 0xC4, 0xC9 or 0xCA ends the frame at once. The reply is the opcode and 0x02, and no register strobe is raised.
- R7: With CRC on, a successful read reply ends with two 0x00 bytes, for 9 bytes in total. With CRC off it is 7 bytes long. Error replies and write replies are always 2 bytes long.
- R8: Internal address CFG_ADDR (default 0x0024) is the configuration register. It is written and read without any register-port strobe, and it resets to 0x0C. When its bits 3:2 are both zero, frames from then on carry no check byte.
- R9: With sel low, a partial frame and any pending reply are discarded. tx_valid is low from the next cycle and no strobe is raised, and the next frame is parsed from its opcode.
- R10: rx_ready stays low while a reply is waiting. While tx_valid is high and tx_ready is low, tx_byte and tx_valid stay unchanged.
- R11: After reset, tx_valid and both strobes are low, rx_ready is high while sel is high, and CRC checking is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Frame select, high while a frame is open |
| rx_valid | input | 1 | Received byte available |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Block accepts a received byte |
| tx_valid | output | 1 | Reply byte available |
| tx_byte | output | 8 | Reply byte |
| tx_ready | input | 1 | Shifter accepts the reply byte |
| reg_wr | output | 1 | Register write strobe, one cycle |
| reg_rd | output | 1 | Register read strobe, one cycle |
| reg_internal | output | 1 | Access targets the internal space |
| reg_clockless | output | 1 | Clockless flag of an internal access |
| reg_addr | output | 24 | Register address |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Read data, valid during reg_rd |

## Verification
A parser that miscounts the bytes of a frame shows up within that frame. The reply either appears a byte early, or never appears while rx_ready stays high. The next frame's echo then carries a wrong opcode. A corrupted field register or CRC state appears as a wrong address or data on the strobe cycle, or as a wrong status byte in the reply that follows. A stale configuration register changes the reply length of the very next read, and it changes whether a check byte is expected.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 24;
  localparam int DATA_W     = 32;
  localparam int IADDR_W    = 15;
  localparam int CFG_W      = 7;
  localparam int MAX_BODY   = 7;
  localparam int BODY_W     = MAX_BODY * BYTE_W;
  localparam int RESP_BYTES = 9;
  localparam int RESP_W     = RESP_BYTES * BYTE_W;
  localparam int CNT_W      = $clog2(RESP_BYTES + 1);

  localparam logic [7:0] OP_SWR = 8'hC9;
  localparam logic [7:0] OP_SRD = 8'hCA;
  localparam logic [7:0] OP_IWR = 8'hC3;
  localparam logic [7:0] OP_IRD = 8'hC4;

  localparam logic [7:0] STAT_OK     = 8'h00;
  localparam logic [7:0] STAT_BADCRC = 8'h01;
  localparam logic [7:0] STAT_BADOP  = 8'h02;
  localparam logic [7:0] READ_HDR    = 8'hF0;

  localparam logic [6:0] CRC_PRESET = 7'h7F;
  localparam logic [6:0] CRC_POLY   = 7'h09;

  typedef enum logic [1:0] {P_OP, P_BODY, P_EXEC, P_WAIT} pstate_t;

  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic [7:0] b);
    logic [6:0] r;
    logic       fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[6] ^ b[i];
      r  = {r[5:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] body_len(input logic [7:0] op);
    case (op)
      OP_SWR:  return CNT_W'(7);
      OP_SRD:  return CNT_W'(3);
      OP_IWR:  return CNT_W'(6);
      OP_IRD:  return CNT_W'(3);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/spi_cmd_crc7.sv
module spi_cmd_crc7
  import spi_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       upd,
  input  logic [7:0] din,
  output logic [6:0] crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= CRC_PRESET;
    else if (start) crc <= crc7_step(CRC_PRESET, din);
    else if (upd)   crc <= crc7_step(crc, din);
  end

endmodule

// File: rtl/spi_cmd_parser.sv
module spi_cmd_parser
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              crc_on,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              rx_ready,
  input  logic              resp_busy,
  output logic              cmd_done,
  output logic [7:0]        cmd_op,
  output logic [7:0]        cmd_status,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_write,
  output logic              cmd_internal,
  output logic              cmd_clockless
);

  pstate_t           state_q;
  logic [7:0]        op_q;
  logic [BODY_W-1:0] body_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  need_q;
  logic              chk_q;
  logic [6:0]        crc_rx_q;
  logic [6:0]        crc_calc;
  logic [CNT_W-1:0]  blen;
  logic              fire;
  logic [7:0]        a_hi;
  logic [7:0]        a_lo;

  assign rx_ready = sel && (state_q == P_OP || state_q == P_BODY);
  assign fire     = rx_valid && rx_ready;
  assign blen     = body_len(op_q);
  assign cmd_done = sel && (state_q == P_EXEC);
  assign cmd_op   = op_q;

  spi_cmd_crc7 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .start (fire && state_q == P_OP),
    .upd   (fire && state_q == P_BODY && cnt_q < blen),
    .din   (rx_byte),
    .crc   (crc_calc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= P_OP;
      op_q     <= '0;
      body_q   <= '0;
      cnt_q    <= '0;
      need_q   <= '0;
      chk_q    <= 1'b0;
      crc_rx_q <= '0;
    end else if (!sel) begin
      state_q <= P_OP;
    end else begin
      case (state_q)
        P_OP: if (fire) begin
          op_q   <= rx_byte;
          body_q <= '0;
          cnt_q  <= '0;
          chk_q  <= crc_on;
          need_q <= body_len(rx_byte) + CNT_W'(crc_on);
          state_q <= (body_len(rx_byte) == '0) ? P_EXEC : P_BODY;
        end
        P_BODY: if (fire) begin
          if (cnt_q < blen) body_q <= {body_q[BODY_W-9:0], rx_byte};
          else              crc_rx_q <= rx_byte[7:1];
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q + 1'b1 == need_q) state_q <= P_EXEC;
        end
        P_EXEC: state_q <= P_WAIT;
        default: if (!resp_busy) state_q <= P_OP;
      endcase
    end
  end

  always_comb begin
    cmd_addr      = '0;
    cmd_data      = '0;
    cmd_write     = 1'b0;
    cmd_internal  = 1'b0;
    cmd_clockless = 1'b0;
    a_hi          = '0;
    a_lo          = '0;
    case (op_q)
      OP_SWR: begin
        cmd_addr  = body_q[55:32];
        cmd_data  = body_q[31:0];
        cmd_write = 1'b1;
      end
      OP_SRD: cmd_addr = body_q[23:0];
      OP_IWR: begin
        a_hi         = body_q[47:40];
        a_lo         = body_q[39:32];
        cmd_data     = body_q[31:0];
        cmd_write    = 1'b1;
        cmd_internal = 1'b1;
      end
      OP_IRD: begin
        a_hi         = body_q[23:16];
        a_lo         = body_q[15:8];
        cmd_internal = 1'b1;
      end
      default: ;
    endcase
    if (cmd_internal) begin
      cmd_addr      = {{(ADDR_W-IADDR_W){1'b0}}, a_hi[6:0], a_lo};
      cmd_clockless = a_hi[7];
    end
  end

  always_comb begin
    if (blen == '0)                          cmd_status = STAT_BADOP;
    else if (chk_q && crc_rx_q != crc_calc)  cmd_status = STAT_BADCRC;
    else                                     cmd_status = STAT_OK;
  end

endmodule

// File: rtl/spi_cmd_resp.sv
module spi_cmd_resp
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              load,
  input  logic [RESP_W-1:0] load_bytes,
  input  logic [CNT_W-1:0]  load_len,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              busy
);

  logic [RESP_W-1:0] sr_q;
  logic [CNT_W-1:0]  left_q;

  assign busy     = (left_q != '0);
  assign tx_valid = sel && busy;
  assign tx_byte  = sr_q[RESP_W-1 -: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (!sel) begin
      left_q <= '0;
    end else if (load) begin
      sr_q   <= load_bytes;
      left_q <= load_len;
    end else if (tx_valid && tx_ready) begin
      sr_q   <= {sr_q[RESP_W-9:0], 8'h00};
      left_q <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/spi_cmd_target.sv
module spi_cmd_target
  import spi_cmd_pkg::*;
#(
  parameter logic [IADDR_W-1:0] CFG_ADDR  = 15'h0024,
  parameter logic [CFG_W-1:0]   CFG_RESET = 7'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_ready,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic              reg_internal,
  output logic              reg_clockless,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);

  logic [CFG_W-1:0]  cfg_q;
  logic              crc_on;
  logic              cmd_done;
  logic [7:0]        cmd_op;
  logic [7:0]        cmd_status;
  logic              cmd_write;
  logic              resp_busy;
  logic              ok;
  logic              is_cfg;
  logic [DATA_W-1:0] rd_word;
  logic [RESP_W-1:0] resp_bytes;
  logic [CNT_W-1:0]  resp_len;

  assign crc_on = |cfg_q[3:2];

  spi_cmd_parser u_parser (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel           (sel),
    .crc_on        (crc_on),
    .rx_valid      (rx_valid),
    .rx_byte       (rx_byte),
    .rx_ready      (rx_ready),
    .resp_busy     (resp_busy),
    .cmd_done      (cmd_done),
    .cmd_op        (cmd_op),
    .cmd_status    (cmd_status),
    .cmd_addr      (reg_addr),
    .cmd_data      (reg_wdata),
    .cmd_write     (cmd_write),
    .cmd_internal  (reg_internal),
    .cmd_clockless (reg_clockless)
  );

  assign ok      = cmd_done && (cmd_status == STAT_OK);
  assign is_cfg  = reg_internal && (reg_addr[IADDR_W-1:0] == CFG_ADDR);
  assign reg_wr  = ok && cmd_write && !is_cfg;
  assign reg_rd  = ok && !cmd_write && !is_cfg;
  assign rd_word = is_cfg ? {{(DATA_W-CFG_W){1'b0}}, cfg_q} : reg_rdata;

  always_comb begin
    if (cmd_status == STAT_OK && !cmd_write) begin
      resp_bytes = {cmd_op, STAT_OK, READ_HDR, rd_word[7:0], rd_word[15:8],
                    rd_word[23:16], rd_word[31:24], 16'h0000};
      resp_len   = crc_on ? CNT_W'(9) : CNT_W'(7);
    end else begin
      resp_bytes = {cmd_op, cmd_status, {(RESP_W-16){1'b0}}};
      resp_len   = CNT_W'(2);
    end
  end

  spi_cmd_resp u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .load       (cmd_done),
    .load_bytes (resp_bytes),
    .load_len   (resp_len),
    .tx_ready   (tx_ready),
    .tx_valid   (tx_valid),
    .tx_byte    (tx_byte),
    .busy       (resp_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cfg_q <= CFG_RESET;
    else if (ok && cmd_write && is_cfg)   cfg_q <= reg_wdata[CFG_W-1:0];
  end

endmodule

// File: rtl/spi_cmd_target_chk.sv
module spi_cmd_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_byte,
  input logic       reg_wr,
  input logic       reg_rd
);

  assert_access_then_reply_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |=> (tx_valid || !sel));

  assert_no_rx_during_reply_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);

  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && sel) |=> (!sel || (tx_valid && $stable(tx_byte))));

  assert_abort_no_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (!reg_wr && !reg_rd));

  assert_abort_drops_reply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !tx_valid);

endmodule

bind spi_cmd_target spi_cmd_target_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel      (sel),
  .rx_ready (rx_ready),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_byte  (tx_byte),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd)
);

// File: tb/spi_cmd_target_test.sv
module spi_cmd_target_test;

  localparam logic [14:0] CFG = 15'h0024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        tx_ready = 1'b0;
  logic        reg_wr, reg_rd, reg_internal, reg_clockless;
  logic [23:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit stall_en = 1;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [23:0] last_wa;
  logic [31:0] last_wd;
  logic last_wi, last_wc;
  logic [6:0] cfg_m = 7'h0C;

  always #2 clk = ~clk;

  spi_cmd_target uut (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_internal(reg_internal),
    .reg_clockless(reg_clockless), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] model_rd(input logic [23:0] a, input logic internal);
    return {a[7:0], a[23:8] ^ 16'h3C96, internal ? 8'hE1 : 8'h1E};
  endfunction

  assign reg_rdata = model_rd(reg_addr, reg_internal);

  always @(posedge clk) begin
    if (rst_n && reg_wr) begin
      wr_cnt++;
      last_wa = reg_addr; last_wd = reg_wdata;
      last_wi = reg_internal; last_wc = reg_clockless;
    end
    if (rst_n && reg_rd) rd_cnt++;
  end

  function automatic logic [6:0] crc7_of(input logic [7:0] b[9], input int n);
    logic [6:0] c = 7'h7F;
    for (int k = 0; k < n; k++)
      for (int i = 7; i >= 0; i--) begin
        logic fb = c[6] ^ b[k][i];
        c = {c[5:0], 1'b0};
        if (fb) c ^= 7'h09;
      end
    return c;
  endfunction

  function automatic bit known_op(input logic [7:0] op);
    return op == 8'hC9 || op == 8'hCA || op == 8'hC3 || op == 8'hC4;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    int guard = 0;
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    while (!rx_ready && guard < 1000) begin @(negedge clk); guard++; end
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic get_byte(output logic [7:0] b);
    int guard = 0;
    forever begin
      @(negedge clk);
      tx_ready = stall_en ? (($urandom % 4) != 0) : 1'b1;
      if (tx_valid && tx_ready) begin
        b = tx_byte;
        @(posedge clk); #1;
        tx_ready = 1'b0;
        break;
      end
      guard++;
      if (guard > 1000) begin b = 8'hXX; break; end
    end
  endtask

  task automatic do_frame(input logic [7:0] op, input logic [23:0] a, input logic [31:0] d,
                          input bit cl, input bit bad, input string req);
    logic [7:0] fb[9];
    int n = 0;
    logic [7:0] st;
    logic [71:0] exp_v = '0, act_v = '0;
    int elen;
    int w0 = wr_cnt, r0 = rd_cnt;
    bit internal = (op == 8'hC3 || op == 8'hC4);
    bit wr = (op == 8'hC9 || op == 8'hC3);
    logic [23:0] ea = internal ? {9'd0, a[14:0]} : a;
    bit hit = internal && a[14:0] == CFG;
    bit crc_m = |cfg_m[3:2];
    logic [31:0] rw;
    for (int i = 0; i < 9; i++) fb[i] = 8'h00;
    fb[n++] = op;
    case (op)
      8'hC9: begin fb[n++]=a[23:16]; fb[n++]=a[15:8]; fb[n++]=a[7:0];
                   fb[n++]=d[31:24]; fb[n++]=d[23:16]; fb[n++]=d[15:8]; fb[n++]=d[7:0]; end
      8'hCA: begin fb[n++]=a[23:16]; fb[n++]=a[15:8]; fb[n++]=a[7:0]; end
      8'hC3: begin fb[n++]={cl,a[14:8]}; fb[n++]=a[7:0];
                   fb[n++]=d[31:24]; fb[n++]=d[23:16]; fb[n++]=d[15:8]; fb[n++]=d[7:0]; end
      8'hC4: begin fb[n++]={cl,a[14:8]}; fb[n++]=a[7:0]; fb[n++]=8'h5A; end
      default: ;
    endcase
    if (known_op(op) && crc_m) begin
      fb[n] = {crc7_of(fb, n), 1'b1} ^ (bad ? 8'h02 : 8'h00);
      n++;
    end
    st = !known_op(op) ? 8'h02 : (crc_m && bad) ? 8'h01 : 8'h00;
    rw = hit ? {25'd0, cfg_m} : model_rd(ea, 1'(internal));
    if (st == 8'h00 && !wr) begin
      exp_v = {op, 8'h00, 8'hF0, rw[7:0], rw[15:8], rw[23:16], rw[31:24], 16'h0};
      elen = crc_m ? 9 : 7;
    end else begin
      exp_v = {op, st, 56'h0};
      elen = 2;
    end
    for (int i = 0; i < n; i++) put_byte(fb[i]);
    for (int i = 0; i < 9; i++) begin
      logic [7:0] b = 8'h00;
      if (i < elen) get_byte(b);
      act_v = {act_v[63:0], b};
    end
    check(act_v === exp_v, req, "reply bytes", act_v, exp_v);
    @(negedge clk);
    check(tx_valid == 1'b0, "R7", "reply length", 72'(tx_valid), 72'(0));
    if (st == 8'h00 && wr && !hit) begin
      check(wr_cnt == w0 + 1 && last_wa == ea && last_wd == d && last_wi == internal &&
            last_wc == (internal ? cl : 1'b0), internal ? "R4" : "R2", "write access",
            {last_wa, last_wd, 14'(0), last_wi, last_wc}, {ea, d, 14'(0), internal, internal ? cl : 1'b0});
    end else begin
      check(wr_cnt == w0, hit ? "R8" : st == 8'h02 ? "R6" : "R5", "no write strobe",
            72'(wr_cnt - w0), 72'(0));
    end
    check(rd_cnt == r0 + ((st == 8'h00 && !wr && !hit) ? 1 : 0),
          hit ? "R8" : "R3", "read strobe count", 72'(rd_cnt - r0),
          72'((st == 8'h00 && !wr && !hit) ? 1 : 0));
    if (st == 8'h00 && wr && hit) cfg_m = d[6:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    int w0;
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1; sel = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(tx_valid == 0 && rx_ready == 1 && reg_wr == 0 && reg_rd == 0, "R11", "reset idle",
          {68'(0), tx_valid, rx_ready, reg_wr, reg_rd}, 72'b0100);

    do_frame(8'hC9, 24'h123456, 32'hDEADBEEF, 0, 0, "R2");
    do_frame(8'hCA, 24'hABCDEF, 32'h0, 0, 0, "R3");
    do_frame(8'hC3, 24'h001234, 32'hCAFEF00D, 1, 0, "R4");
    do_frame(8'hC4, 24'h007F01, 32'h0, 0, 0, "R4");
    do_frame(8'hC4, 24'h000155, 32'h0, 1, 0, "R4");
    do_frame(8'hC9, 24'h0F0F0F, 32'h11111111, 0, 1, "R5");
    do_frame(8'hCA, 24'h0F0F0F, 32'h0, 0, 1, "R5");
    do_frame(8'hC1, 24'h0, 32'h0, 0, 0, "R6");
    do_frame(8'h00, 24'h0, 32'h0, 0, 0, "R6");
    do_frame(8'hC4, {9'd0, CFG}, 32'h0, 0, 0, "R8");
    do_frame(8'hC3, {9'd0, CFG}, 32'h00000050, 0, 0, "R8");
    do_frame(8'hC4, {9'd0, CFG}, 32'h0, 0, 0, "R8");
    do_frame(8'hCA, 24'h456789, 32'h0, 0, 0, "R7");
    do_frame(8'hC9, 24'h222222, 32'h87654321, 0, 1, "R8");
    do_frame(8'hC3, {9'd0, CFG}, 32'h0000000C, 1, 0, "R8");
    do_frame(8'hCA, 24'h456789, 32'h0, 0, 0, "R7");

    // R9 abort inside a frame
    w0 = wr_cnt;
    put_byte(8'hC9); put_byte(8'h01); put_byte(8'h02); put_byte(8'h03);
    @(negedge clk); sel = 1'b0;
    @(negedge clk); sel = 1'b1;
    do_frame(8'hCA, 24'h00BEEF, 32'h0, 0, 0, "R9");
    check(wr_cnt == w0, "R9", "aborted write dropped", 72'(wr_cnt - w0), 72'(0));

    // R9 abort during reply
    begin
      logic [7:0] fb[9];
      for (int i = 0; i < 9; i++) fb[i] = 8'h00;
      fb[0] = 8'hCA; fb[1] = 8'h10; fb[2] = 8'h20; fb[3] = 8'h30;
      fb[4] = {crc7_of(fb, 4), 1'b1};
      for (int i = 0; i < 5; i++) put_byte(fb[i]);
      get_byte(b); get_byte(b);
      @(negedge clk); sel = 1'b0;
      @(negedge clk);
      check(tx_valid == 0, "R9", "reply dropped while sel low", 72'(tx_valid), 72'(0));
      sel = 1'b1;
      @(negedge clk);
      check(tx_valid == 0 && rx_ready == 1, "R9", "idle after abort",
            {70'(0), tx_valid, rx_ready}, 72'b01);
    end
    do_frame(8'hC4, 24'h000321, 32'h0, 1, 0, "R9");

    // R10 back-pressure
    begin
      logic [7:0] fb[9];
      logic [7:0] held;
      for (int i = 0; i < 9; i++) fb[i] = 8'h00;
      fb[0] = 8'hCA; fb[1] = 8'hAA; fb[2] = 8'hBB; fb[3] = 8'hCC;
      fb[4] = {crc7_of(fb, 4), 1'b1};
      for (int i = 0; i < 5; i++) put_byte(fb[i]);
      tx_ready = 1'b0;
      repeat (2) @(negedge clk);
      held = tx_byte;
      check(tx_valid == 1 && held == 8'hCA, "R10", "first reply byte", 72'(held), 72'hCA);
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        check(tx_valid == 1 && tx_byte == held && rx_ready == 0, "R10", "hold under stall",
              {62'(0), tx_valid, rx_ready, tx_byte}, {62'(0), 1'b1, 1'b0, held});
      end
      for (int i = 0; i < 9; i++) get_byte(b);
      @(negedge clk);
    end

    // random frames
    for (int t = 0; t < 150; t++) begin
      int pick = $urandom % 10;
      logic [7:0] op;
      logic [23:0] a = 24'($urandom);
      logic [31:0] d = $urandom;
      bit bad = ($urandom % 8) == 0;
      bit cl = 1'($urandom);
      if (pick < 3) op = 8'hC9;
      else if (pick < 5) op = 8'hCA;
      else if (pick < 7) op = 8'hC3;
      else if (pick < 9) op = 8'hC4;
      else begin
        op = 8'hC0 + 8'($urandom % 16);
        if (known_op(op)) op = 8'hC5;
      end
      if (a[14:0] == CFG) a[0] = ~a[0];
      do_frame(op, a, d, cl, bad, op == 8'hC9 ? "R2" : op == 8'hCA ? "R3" :
               known_op(op) ? "R4" : "R6");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule